// File: doc/BRIEF.md
# Reset Strap Capture Register

This block turns a 24-bit address bus into a source of configuration straps. While reset is held, and for the one clock cycle that follows its release, the block keeps its address drivers switched off so that external pull resistors set the level on each pin. On the first rising clock edge after reset goes away, it latches all 24 pad levels into a configuration register. From the next cycle on, it enables the drivers and passes the core's address through to the pads.

The captured word stays fixed until the next reset. A set of fixed fields is decoded from it into control outputs: core clock selection, PCI clock rate, PCI arbiter enable, PCI host mode and flash data width. A core-speed pattern that is not defined raises a flag, and the decode then falls back to the slowest speed. Software can read the raw word through a small read port.

Top module: `strap_latch`

## Requirements
- R1: While rst_n is low, addr_oe_o, cfg_o, rd_data_o and every decoded output (core_sel_o, strap_bad_o, pci_66m_o, pci_arb_en_o, pci_host_o, flash_8bit_o) are 0, and addr_pad_o is 0.
- R2: On the first rising clock edge after rst_n goes high, cfg_o takes the value on addr_pad_i, with pad bit n stored in cfg_o bit n.
- R3: addr_oe_o stays 0 from the release of reset until that capture edge, and becomes 1 on that edge. While addr_oe_o is 0, addr_pad_o is 0. While addr_oe_o is 1, addr_pad_o equals addr_core_i.
- R4: After the capture, changes on addr_pad_i have no effect on cfg_o or on the decoded outputs until the next reset.
- R5: The core-speed field is cfg bits [23:21]. Pattern 100 gives core_sel_o = 2 (533 MHz), pattern 001 gives core_sel_o = 1 (400 MHz), and pattern 011 gives core_sel_o = 0 (266 MHz). For each of these patterns strap_bad_o is 0.
- R6: Any other pattern in cfg bits [23:21] sets strap_bad_o to 1 after capture and forces core_sel_o to 0, the slowest speed.
- R7: pci_66m_o equals cfg bit 4 (0 means 33 MHz, 1 means 66 MHz).
- R8: pci_arb_en_o equals cfg bit 2 (1 enables the arbiter), and pci_host_o equals cfg bit 1 (1 means host).
- R9: flash_8bit_o equals cfg bit 0 (0 means a 16-bit flash bus, 1 means an 8-bit flash bus).
- R10: rd_data_o equals the captured word when rd_en_i is 1, and is 0 when rd_en_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_pad_i | input | 24 | Levels seen on the address pads |
| addr_core_i | input | 24 | Address to drive once straps are captured |
| addr_pad_o | output | 24 | Address value toward the pad drivers |
| addr_oe_o | output | 1 | Pad driver enable |
| cfg_o | output | 24 | Captured strap word |
| core_sel_o | output | 2 | Core speed: 0 = 266, 1 = 400, 2 = 533 MHz |
| strap_bad_o | output | 1 | Core-speed pattern not defined |
| pci_66m_o | output | 1 | PCI clock runs at 66 MHz |
| pci_arb_en_o | output | 1 | PCI arbiter enabled |
| pci_host_o | output | 1 | Device acts as PCI host |
| flash_8bit_o | output | 1 | Flash bus is 8 bits wide |
| rd_en_i | input | 1 | Read strobe for the strap word |
| rd_data_o | output | 24 | Read data |

## Verification
The bench releases reset in the middle of a cycle and checks that the drivers are still off before the capture edge. A design that enabled them on release would drive the pads and corrupt the straps it is about to sample. After capture, the bench drives new values onto the pads, so a register that kept loading would show the wrong word. Every core-speed pattern is covered, including the five undefined ones: a decode that passed an undefined pattern through, or failed to flag it, would select a clock the part cannot run. Random strap words with a fixed seed exercise the single-bit fields, where a shifted bit position or a swapped field would give a mismatch.

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_pad_i,
  input  logic [ADDR_W-1:0] addr_core_i,
  output logic [ADDR_W-1:0] addr_pad_o,
  output logic              addr_oe_o,
  output logic [ADDR_W-1:0] cfg_o,
  output logic [1:0]        core_sel_o,
  output logic              strap_bad_o,
  output logic              pci_66m_o,
  output logic              pci_arb_en_o,
  output logic              pci_host_o,
  output logic              flash_8bit_o,
  input  logic              rd_en_i,
  output logic [ADDR_W-1:0] rd_data_o
);
  localparam int SPD_HI  = 23;
  localparam int SPD_LO  = 21;
  localparam int PCI66_B = 4;
  localparam int ARB_B   = 2;
  localparam int HOST_B  = 1;
  localparam int FW_B    = 0;

  logic [ADDR_W-1:0] cfg_q;
  logic              done_q;
  logic [2:0]        spd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cfg_q  <= addr_pad_i;
      done_q <= 1'b1;
    end
  end

  assign spd = cfg_q[SPD_HI:SPD_LO];

  always_comb begin
    core_sel_o  = 2'd0;
    strap_bad_o = 1'b0;
    case (spd)
      3'b100: core_sel_o = 2'd2;
      3'b001: core_sel_o = 2'd1;
      3'b011: core_sel_o = 2'd0;
      default: strap_bad_o = done_q;
    endcase
  end

  assign addr_oe_o    = done_q;
  assign addr_pad_o   = done_q ? addr_core_i : '0;
  assign cfg_o        = cfg_q;
  assign pci_66m_o    = cfg_q[PCI66_B];
  assign pci_arb_en_o = cfg_q[ARB_B];
  assign pci_host_o   = cfg_q[HOST_B];
  assign flash_8bit_o = cfg_q[FW_B];
  assign rd_data_o    = rd_en_i ? cfg_q : '0;
endmodule

// File: rtl/strap_latch_chk.sv
module strap_latch_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_pad_i,
  input logic [ADDR_W-1:0] addr_pad_o,
  input logic              addr_oe_o,
  input logic [ADDR_W-1:0] cfg_o,
  input logic [1:0]        core_sel_o,
  input logic              strap_bad_o
);
  // R2
  capture_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_oe_o) |-> cfg_o == $past(addr_pad_i));

  // R3
  oe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe_o |=> addr_oe_o);

  // R3
  pads_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_oe_o |-> addr_pad_o == '0);

  // R4
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe_o |=> $stable(cfg_o));

  // R6
  bad_slowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strap_bad_o |-> core_sel_o == 2'd0);
endmodule

bind strap_latch strap_latch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_pad_i(addr_pad_i), .addr_pad_o(addr_pad_o),
  .addr_oe_o(addr_oe_o), .cfg_o(cfg_o), .core_sel_o(core_sel_o),
  .strap_bad_o(strap_bad_o)
);

// File: tb/strap_latch_tb_top.sv
module strap_latch_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [23:0] pad_i = '0, core_i = '0;
  logic        rd_en = 0;
  logic [23:0] pad_o, cfg, rd_data;
  logic        oe, bad, p66, arb, host, f8;
  logic [1:0]  csel;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  strap_latch dut_i (
    .clk(clk), .rst_n(rst_n), .addr_pad_i(pad_i), .addr_core_i(core_i),
    .addr_pad_o(pad_o), .addr_oe_o(oe), .cfg_o(cfg), .core_sel_o(csel),
    .strap_bad_o(bad), .pci_66m_o(p66), .pci_arb_en_o(arb),
    .pci_host_o(host), .flash_8bit_o(f8), .rd_en_i(rd_en), .rd_data_o(rd_data)
  );

  function automatic logic [1:0] exp_sel(input logic [23:0] w);
    case (w[23:21])
      3'b100:  return 2'd2;
      3'b001:  return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic exp_bad(input logic [23:0] w);
    return !(w[23:21] == 3'b100 || w[23:21] == 3'b001 || w[23:21] == 3'b011);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_decode(input logic [23:0] w);
    chk("R2 cfg", cfg, w);
    chk("R5 core_sel", csel, exp_sel(w));
    chk("R6 strap_bad", bad, exp_bad(w));
    chk("R7 pci_66m", p66, w[4]);
    chk("R8 arb", arb, w[2]);
    chk("R8 host", host, w[1]);
    chk("R9 flash_8bit", f8, w[0]);
  endtask

  task automatic run_one(input logic [23:0] w);
    @(negedge clk);
    rst_n = 0; pad_i = w; core_i = $urandom; rd_en = 1;
    repeat (2) @(negedge clk);
    // R1
    chk("R1 oe", oe, 0); chk("R1 cfg", cfg, 0); chk("R1 pad_o", pad_o, 0);
    chk("R1 rd", rd_data, 0);
    chk("R1 dec", {csel, bad, p66, arb, host, f8}, 0);
    rst_n = 1;
    #2;
    // R3 sampling cycle
    chk("R3 oe before capture", oe, 0);
    chk("R3 pad_o before capture", pad_o, 0);
    @(negedge clk);
    check_decode(w);
    chk("R3 oe after capture", oe, 1);
    chk("R3 pad_o drives core", pad_o, core_i);
    chk("R10 rd on", rd_data, w);
    rd_en = 0;
    #1 chk("R10 rd off", rd_data, 0);
    pad_i = ~w; core_i = $urandom;
    repeat (3) @(negedge clk);
    // R4
    chk("R4 hold", cfg, w);
    check_decode(w);
    chk("R3 pad_o follows", pad_o, core_i);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    for (int c = 0; c < 8; c++) begin
      logic [23:0] w;
      w = $urandom;
      w[23:21] = c[2:0];
      run_one(w);
    end
    run_one(24'h800017);
    run_one(24'h000000);
    run_one(24'hFFFFFF);
    for (int i = 0; i < 30; i++) begin
      logic [23:0] w;
      w = $urandom;
      if (i % 3 == 0) w[23:21] = 3'b100;
      run_one(w);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule